// File: doc/BRIEF.md
# Three-Channel Down-Counter and Time-Match Timer

This block holds three independent 32-bit timer channels behind a small word-addressed register bus. Each channel has three words: a configuration word, a preload word and a live counter word. The configuration word picks one of four behaviours for the channel:

- count down and halt at zero,
- count down and refill from the preload word on expiry,
- wait once for the counter word to equal a chosen system-time value,
- stay idle.

Three system-time buses enter the block, and each channel picks one of them as its time base. Each channel drives its own single-cycle interrupt pulse toward a separate interrupt-status block. That block owns masking and status, and it is not part of this design.

Software writes the preload and counter words, then selects a mode. The bus is single-cycle. A write is captured on the clock edge where `bus_wr` is high. A read is combinational from `bus_addr`. An asynchronous active-low reset is synchronised inside the block before it reaches the channel registers.

Top module: `tri_chan_timer`

## Requirements
- R1: The word address is `bus_addr[5:2]`, and `bus_addr[1:0]` must be 00 for any access.
  - Configuration words sit at 0x00, 0x04 and 0x08 for channels 0, 1 and 2.
  - Preload words sit at 0x0C, 0x10 and 0x14.
  - Counter words sit at 0x18, 0x1C and 0x20.
  - A configuration word keeps only bits [3:0] and reads zero above them.
  - Any other address reads zero, and a write to it changes no register.
- R2: After reset, every register reads zero and `irq_pulse` is zero.
- R3: Configuration bits [1:0] = 00 selects stop mode.
  - A nonzero counter decrements by one per clock and stays at zero once it gets there.
  - `irq_pulse[ch]` is high for exactly the one cycle in which the counter first reads zero after holding 1.
- R4: Configuration bits [1:0] = 01 selects reload mode.
  - A counter holding 1 is loaded from the preload word on the next edge, instead of becoming 0, and the interrupt pulses in that cycle.
  - A counter at zero stays at zero and gives no interrupt.
- R5: Configuration bits [1:0] = 10 selects match mode.
  - The counter word does not change.
  - While the channel is armed, the first edge at which the selected time value equals the counter word raises a one-cycle interrupt and disarms the channel.
  - A write to the counter word re-arms the channel.
- R6: Configuration bits [3:2] select the channel's time base: 00 selects `time_a`, 01 selects `time_b`, 10 selects `time_c`, and 11 selects `time_a`.
- R7: Configuration bits [1:0] = 11 selects idle mode: the counter holds its value and no interrupt is raised.
- R8: A bus write to a counter word sets the new value on the next edge. That write overrides a decrement, a reload or a match due in the same cycle, and no interrupt is raised for that cycle.
- R9: `irq_pulse[ch]` is driven only by channel `ch`. A channel's activity never raises another channel's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, captured on the rising edge |
| bus_addr | input | 6 | Byte address of the word being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| time_a | input | 32 | System-time value, source A |
| time_b | input | 32 | System-time value, source B |
| time_c | input | 32 | System-time value, source C |
| irq_pulse | output | 3 | One-cycle interrupt pulse per channel |

## Verification
The sharpest collision is a software write to a counter word landing in the same cycle as the counter's own expiry. The bench provokes it by loading 2 and then issuing the next write exactly when the counter reads 1, in both stop and reload modes. The written value must appear, the decrement or reload must not, and no interrupt may be raised.

The same collision is provoked in match mode by rewriting the counter word while the selected time already equals it. The interrupt must be suppressed on the write edge and must then fire one cycle later, because the write re-armed the channel.

// File: rtl/tct_pkg.sv
package tct_pkg;

  typedef enum logic [1:0] {
    MODE_STOP   = 2'b00,
    MODE_RELOAD = 2'b01,
    MODE_MATCH  = 2'b10,
    MODE_IDLE   = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    SRC_A   = 2'b00,
    SRC_B   = 2'b01,
    SRC_C   = 2'b10,
    SRC_ALT = 2'b11
  } tmr_src_e;

  typedef struct packed {
    tmr_src_e  src;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam int CFG_W = $bits(tmr_cfg_t);

endpackage

// File: rtl/tct_rst_sync.sv
module tct_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/tct_regdec.sv
module tct_regdec import tct_pkg::*; #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [NUM_CH-1:0][CFG_W-1:0]   cfg_rd,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  pre_rd,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  cnt_rd,
  output logic [NUM_CH-1:0]              cfg_we,
  output logic [NUM_CH-1:0]              pre_we,
  output logic [NUM_CH-1:0]              cnt_we,
  output logic [DATA_W-1:0]              bus_rdata
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             aligned;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_strobe
    localparam int CFG_IDX = ch;
    localparam int PRE_IDX = ch + NUM_CH;
    localparam int CNT_IDX = ch + 2 * NUM_CH;
    assign cfg_we[ch] = bus_wr && aligned && (word_idx == IDX_W'(CFG_IDX));
    assign pre_we[ch] = bus_wr && aligned && (word_idx == IDX_W'(PRE_IDX));
    assign cnt_we[ch] = bus_wr && aligned && (word_idx == IDX_W'(CNT_IDX));
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (word_idx == IDX_W'(ch)) begin
          bus_rdata = {{(DATA_W-CFG_W){1'b0}}, cfg_rd[ch]};
        end
        if (word_idx == IDX_W'(ch + NUM_CH)) begin
          bus_rdata = pre_rd[ch];
        end
        if (word_idx == IDX_W'(ch + 2 * NUM_CH)) begin
          bus_rdata = cnt_rd[ch];
        end
      end
    end
  end

endmodule

// File: rtl/tct_time_sel.sv
module tct_time_sel import tct_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] time_a,
  input  logic [DATA_W-1:0] time_b,
  input  logic [DATA_W-1:0] time_c,
  output logic [DATA_W-1:0] time_out
);

  always_comb begin
    unique case (tmr_src_e'(sel))
      SRC_B:   time_out = time_b;
      SRC_C:   time_out = time_c;
      default: time_out = time_a;
    endcase
  end

endmodule

// File: rtl/tct_channel.sv
module tct_channel import tct_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              pre_we,
  input  logic              cnt_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] sys_time,
  output logic [CFG_W-1:0]  cfg_out,
  output logic [DATA_W-1:0] pre_out,
  output logic [DATA_W-1:0] cnt_out,
  output logic              armed_out,
  output logic              irq_out
);

  tmr_cfg_t          cfg_q, cfg_d;
  logic [DATA_W-1:0] pre_q, pre_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              armed_q, armed_d;
  logic              irq_q, irq_d;
  logic              cnt_en, armed_en;
  logic              cnt_is_zero, cnt_is_one, time_hit;

  assign cnt_is_zero = (cnt_q == '0);
  assign cnt_is_one  = (cnt_q == DATA_W'(1));
  assign time_hit    = (sys_time == cnt_q);

  // next-state: configuration and preload
  always_comb begin
    cfg_d = cfg_q;
    pre_d = pre_q;
    if (cfg_we) cfg_d = tmr_cfg_t'(wdata[CFG_W-1:0]);
    if (pre_we) pre_d = wdata;
  end

  // next-state: counter, arm flag and interrupt
  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    irq_d   = 1'b0;
    if (cnt_we) begin
      cnt_d   = wdata;
      armed_d = 1'b1;
    end else begin
      unique case (cfg_q.mode)
        MODE_STOP: begin
          if (!cnt_is_zero) begin
            cnt_d = cnt_q - DATA_W'(1);
            irq_d = cnt_is_one;
          end
        end
        MODE_RELOAD: begin
          if (!cnt_is_zero) begin
            cnt_d = cnt_is_one ? pre_q : (cnt_q - DATA_W'(1));
            irq_d = cnt_is_one;
          end
        end
        MODE_MATCH: begin
          if (armed_q && time_hit) begin
            armed_d = 1'b0;
            irq_d   = 1'b1;
          end
        end
        default: begin
        end
      endcase
    end
  end

  assign cnt_en   = cnt_we || (cnt_d != cnt_q);
  assign armed_en = cnt_we || (armed_d != armed_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_we) begin
      pre_q <= pre_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (armed_en) begin
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign cfg_out   = cfg_q;
  assign pre_out   = pre_q;
  assign cnt_out   = cnt_q;
  assign armed_out = armed_q;
  assign irq_out   = irq_q;

endmodule

// File: rtl/tri_chan_timer.sv
module tri_chan_timer import tct_pkg::*; #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] time_a,
  input  logic [DATA_W-1:0] time_b,
  input  logic [DATA_W-1:0] time_c,
  output logic [NUM_CH-1:0] irq_pulse
);

  logic                          rst_n_sync;
  logic [NUM_CH-1:0]             cfg_we_v, pre_we_v, cnt_we_v;
  logic [NUM_CH-1:0][CFG_W-1:0]  cfg_v;
  logic [NUM_CH-1:0][DATA_W-1:0] pre_v, cnt_v, time_v;
  logic [NUM_CH-1:0][1:0]        mode_v;
  logic [NUM_CH-1:0]             armed_v;

  tct_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  tct_regdec #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) regdec_i (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .cfg_rd    (cfg_v),
    .pre_rd    (pre_v),
    .cnt_rd    (cnt_v),
    .cfg_we    (cfg_we_v),
    .pre_we    (pre_we_v),
    .cnt_we    (cnt_we_v),
    .bus_rdata (bus_rdata)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    tct_time_sel #(.DATA_W(DATA_W)) tsel_i (
      .sel      (cfg_v[ch][CFG_W-1:2]),
      .time_a   (time_a),
      .time_b   (time_b),
      .time_c   (time_c),
      .time_out (time_v[ch])
    );

    tct_channel #(.DATA_W(DATA_W)) chan_i (
      .clk       (clk),
      .rst_n     (rst_n_sync),
      .cfg_we    (cfg_we_v[ch]),
      .pre_we    (pre_we_v[ch]),
      .cnt_we    (cnt_we_v[ch]),
      .wdata     (bus_wdata),
      .sys_time  (time_v[ch]),
      .cfg_out   (cfg_v[ch]),
      .pre_out   (pre_v[ch]),
      .cnt_out   (cnt_v[ch]),
      .armed_out (armed_v[ch]),
      .irq_out   (irq_pulse[ch])
    );

    assign mode_v[ch] = cfg_v[ch][1:0];
  end

endmodule

// File: rtl/tct_checker.sv
module tct_checker import tct_pkg::*; #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CH-1:0]             cnt_we,
  input logic [DATA_W-1:0]             wdata,
  input logic [NUM_CH-1:0][1:0]        mode,
  input logic [NUM_CH-1:0][DATA_W-1:0] cnt,
  input logic [NUM_CH-1:0][DATA_W-1:0] pre,
  input logic [NUM_CH-1:0]             armed,
  input logic [NUM_CH-1:0]             irq
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_wr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we[i] |=> (cnt[i] == $past(wdata)) && !irq[i]);

    p_stop_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] == MODE_STOP && !cnt_we[i] && cnt[i] != '0)
        |=> cnt[i] == $past(cnt[i]) - DATA_W'(1));

    p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] == MODE_STOP && !cnt_we[i] && cnt[i] == '0)
        |=> cnt[i] == '0 && !irq[i]);

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] == MODE_RELOAD && !cnt_we[i] && cnt[i] == DATA_W'(1))
        |=> cnt[i] == $past(pre[i]) && irq[i]);

    p_cnt_irq_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] inside {MODE_STOP, MODE_RELOAD} && !cnt_we[i] && cnt[i] != DATA_W'(1))
        |=> !irq[i]);

    p_match_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] == MODE_MATCH && !cnt_we[i] && !armed[i]) |=> !irq[i] && !armed[i]);

    p_match_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] == MODE_MATCH && !cnt_we[i]) |=> $stable(cnt[i]));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] == MODE_IDLE && !cnt_we[i]) |=> $stable(cnt[i]) && !irq[i]);
  end

endmodule

bind tri_chan_timer tct_checker #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_n_sync),
  .cnt_we (cnt_we_v),
  .wdata  (bus_wdata),
  .mode   (mode_v),
  .cnt    (cnt_v),
  .pre    (pre_v),
  .armed  (armed_v),
  .irq    (irq_pulse)
);

// File: tb/tri_chan_timer_tb_top.sv
`timescale 1ns/1ps
module tri_chan_timer_tb_top;

  localparam int NCH = 3;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [5:0]    bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [DW-1:0] time_a, time_b, time_c;
  logic [NCH-1:0] irq_pulse;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tri_chan_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .time_a    (time_a),
    .time_b    (time_b),
    .time_c    (time_c),
    .irq_pulse (irq_pulse)
  );

  function automatic logic [5:0] cfg_a(input int ch); return 6'(ch * 4); endfunction
  function automatic logic [5:0] pre_a(input int ch); return 6'(12 + ch * 4); endfunction
  function automatic logic [5:0] cnt_a(input int ch); return 6'(24 + ch * 4); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic others_quiet(input int ch, input string req);
    logic [NCH-1:0] m;
    m = irq_pulse;
    m[ch] = 1'b0;
    check(req, 32'(m), 32'd0);
  endtask

  initial begin
    #900000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] vals [3];
    vals[0] = 32'd10; vals[1] = 32'd20; vals[2] = 32'd30;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    time_a = '0; time_b = '0; time_c = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state
    for (int w = 0; w < 9; w++) begin
      rd(6'(w * 4), v);
      check("R2 reset register", v, 32'd0);
    end
    check("R2 reset irq", 32'(irq_pulse), 32'd0);

    // R1: map, config width, unmapped and misaligned addresses
    for (int ch = 0; ch < NCH; ch++) begin
      wr(cfg_a(ch), 32'hFFFF_FFF3);
      wr(pre_a(ch), 32'h1234_0000 + 32'(ch));
      wr(cnt_a(ch), 32'hA500_0000 + 32'(ch));
    end
    wr(6'h24, 32'hDEAD_BEEF);
    wr(6'h3C, 32'hDEAD_BEEF);
    wr(6'h19, 32'hDEAD_BEEF);
    for (int ch = 0; ch < NCH; ch++) begin
      rd(cfg_a(ch), v); check("R1 cfg readback", v, 32'h3);
      rd(pre_a(ch), v); check("R1 preload readback", v, 32'h1234_0000 + 32'(ch));
      rd(cnt_a(ch), v); check("R1 counter readback", v, 32'hA500_0000 + 32'(ch));
    end
    rd(6'h24, v); check("R1 unmapped read", v, 32'd0);
    rd(6'h3C, v); check("R1 unmapped read", v, 32'd0);
    rd(6'h19, v); check("R1 misaligned read", v, 32'd0);

    // R3 / R9: stop mode sweep
    for (int ch = 0; ch < NCH; ch++) begin
      for (int n = 1; n <= 5; n++) begin
        wr(cfg_a(ch), 32'h0);
        wr(cnt_a(ch), 32'(n));
        for (int k = 1; k <= n + 2; k++) begin
          @(negedge clk);
          rd(cnt_a(ch), v);
          check("R3 stop count", v, (n > k) ? 32'(n - k) : 32'd0);
          check("R3 stop irq", 32'(irq_pulse[ch]), (k == n) ? 32'd1 : 32'd0);
          others_quiet(ch, "R9 irq isolation");
        end
      end
    end

    // R4: reload mode, model computed in bench
    for (int ch = 0; ch < NCH; ch++) begin
      for (int pi = 0; pi < 4; pi++) begin
        int p, m;
        p = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 3 : 5;
        wr(cfg_a(ch), 32'h1);
        wr(pre_a(ch), 32'(p));
        wr(cnt_a(ch), 32'd3);
        m = 3;
        for (int k = 1; k <= 10; k++) begin
          int exp_irq;
          exp_irq = (m == 1) ? 1 : 0;
          if (m != 0) m = (m == 1) ? p : m - 1;
          @(negedge clk);
          rd(cnt_a(ch), v);
          check("R4 reload count", v, 32'(m));
          check("R4 reload irq", 32'(irq_pulse[ch]), 32'(exp_irq));
        end
      end
    end

    // R8: write collides with expiry (stop, then reload)
    wr(cfg_a(2), 32'h0);
    wr(cnt_a(2), 32'd2);
    wr(cnt_a(2), 32'd7);
    rd(cnt_a(2), v); check("R8 write beats decrement", v, 32'd7);
    check("R8 no irq on write", 32'(irq_pulse[2]), 32'd0);
    @(negedge clk);
    rd(cnt_a(2), v); check("R8 count resumes", v, 32'd6);
    wr(cfg_a(2), 32'h1);
    wr(pre_a(2), 32'd9);
    wr(cnt_a(2), 32'd2);
    wr(cnt_a(2), 32'd4);
    rd(cnt_a(2), v); check("R8 write beats reload", v, 32'd4);
    check("R8 no irq on write", 32'(irq_pulse[2]), 32'd0);

    // R5: match mode on channel 1, source B
    wr(cfg_a(1), 32'h6);
    wr(cnt_a(1), 32'd100);
    time_b = 32'd99;
    @(negedge clk);
    check("R5 no irq before match", 32'(irq_pulse[1]), 32'd0);
    time_b = 32'd100;
    @(negedge clk);
    check("R5 match irq", 32'(irq_pulse[1]), 32'd1);
    rd(cnt_a(1), v); check("R5 counter held", v, 32'd100);
    @(negedge clk);
    check("R5 one-shot", 32'(irq_pulse[1]), 32'd0);
    @(negedge clk);
    check("R5 stays disarmed", 32'(irq_pulse[1]), 32'd0);
    wr(cnt_a(1), 32'd100);
    check("R8 match suppressed on write", 32'(irq_pulse[1]), 32'd0);
    @(negedge clk);
    check("R5 rearmed by write", 32'(irq_pulse[1]), 32'd1);
    time_b = 32'd0;

    // R6: time base selection sweep
    for (int sel = 0; sel < 4; sel++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        for (int cand = 0; cand < 3; cand++) begin
          int want;
          want = (sel == 1) ? 1 : (sel == 2) ? 2 : 0;
          time_a = '0; time_b = '0; time_c = '0;
          wr(cfg_a(ch), 32'((sel << 2) | 2));
          wr(cnt_a(ch), vals[cand]);
          time_a = vals[0]; time_b = vals[1]; time_c = vals[2];
          @(negedge clk);
          check("R6 source select", 32'(irq_pulse[ch]), (cand == want) ? 32'd1 : 32'd0);
          time_a = '0; time_b = '0; time_c = '0;
        end
      end
    end

    // R7: idle mode
    wr(cfg_a(0), 32'h3);
    wr(cnt_a(0), 32'd5);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rd(cnt_a(0), v);
      check("R7 idle count", v, 32'd5);
      check("R7 idle irq", 32'(irq_pulse[0]), 32'd0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule